// File: doc/BRIEF.md
# Buffered Timer/Counter

A bus-mapped timer/counter for a small microcontroller-style peripheral bus. It advances either once per instruction cycle (the block clock) or on edges of an external input pin. The pin passes through a synchronizer and an edge detector, and the edge polarity is selectable. A power-of-two prescaler can be inserted in front of the counter. The counter runs as an 8-bit or a 16-bit counter. A wrap sets a sticky interrupt flag.

The bus sees four locations: a control byte, the counter's low byte, a high-byte buffer and the flag. The true high byte is reached only through the buffer. A read of the low byte copies the live high byte into the buffer. In 16-bit mode a write of the low byte also loads the high byte from the buffer. Both 16-bit reads and 16-bit writes are therefore coherent. A write of the low byte clears the prescaler and holds the counter still for two cycles.

Top module: `tmr_unit`

## Requirements
- R1: After reset the control byte reads 0xFF (enabled, 8-bit, pin source, falling edge, prescaler bypassed, code 7). The low byte, the buffer and the flag read 0.
- R2: The control byte is bit7 enable, bit6 8-bit mode, bit5 pin source, bit4 falling-edge select, bit3 prescaler bypass, bits2:0 prescale code. With the internal source and the bypass set, the counter advances by one per clock cycle.
- R3: With the bypass clear, the counter advances once every 2^(code+1) source events.
- R4: With the pin source selected, the counter counts rising pin edges when bit4 is 0 and falling pin edges when bit4 is 1. Each count lands within four cycles of the edge.
- R5: Address map: 0 control, 1 low byte, 2 high buffer, 3 flag (bit0). A read of address 1 (rd_i high) copies the live high byte into the buffer. Later counting leaves the buffer unchanged until the next such read.
- R6: In 16-bit mode a write of address 1 loads the low byte from the data and the high byte from the buffer in the same cycle.
- R7: After a write of the low byte, the counter does not advance on the next two clock edges.
- R8: A write of the low byte clears the prescaler, so the next count comes a full prescale period later.
- R9: In 8-bit mode the low byte wraps from 0xFF to 0x00 and sets the flag. The high byte is left unchanged.
- R10: In 16-bit mode the counter wraps from 0xFFFF to 0x0000 and sets the flag.
- R11: The flag, also driven on irq_o, stays set until a write to address 3 clears it.
- R12: With enable clear, neither the counter nor the prescaler advances. Writes of the low byte still load the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External count input, asynchronous |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect on address 1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Overflow flag |

## Verification
The assertions check on every cycle that the counter holds during the two-cycle hold after a load, and that it holds while disabled. They also check that the high byte stays frozen in 8-bit mode, that the flag stays set until cleared, and that a low-byte read fills the buffer with the live high byte. Only the bench scenarios can show the prescale ratios and the prescaler restart after a write. The same holds for the pin polarity selection, for coherent 16-bit reads across a carry into the high byte, and for the wrap points in both widths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HBUF = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              run;
    logic              narrow;
    logic              ext_src;
    logic              fall_edge;
    logic              no_div;
    logic [CODE_W-1:0] div_code;
  } ctrl_t;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;

  assign edge_o = fall_i ? (prev_q & ~cur) : (~prev_q & cur);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              clr_i,
  input  logic              bypass_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int PRE_W = 2 ** CODE_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(code_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (adv_i) pre_q <= pre_q + 1'b1;

  assign tick_o = bypass_i ? adv_i : (adv_i & ((pre_q & mask) == mask));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BYTE_W  = 8,
  parameter int INH_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                narrow_i,
  input  logic                load_i,
  input  logic [BYTE_W-1:0]   load_lo_i,
  input  logic [BYTE_W-1:0]   load_hi_i,
  input  logic                inc_i,
  input  logic                flag_clr_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                flag_o,
  output logic                run_o
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int INH_W = $clog2(INH_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [INH_W-1:0] inh_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = inc_i & ~load_i &
                (narrow_i ? (cnt_q[BYTE_W-1:0] == '1) : (cnt_q == '1));
  assign run_o = en_i & (inh_q == '0) & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      inh_q <= '0;
    end else if (load_i) begin
      cnt_q[BYTE_W-1:0] <= load_lo_i;
      if (!narrow_i) cnt_q[CNT_W-1:BYTE_W] <= load_hi_i;
      inh_q <= INH_W'(INH_CYC);
    end else begin
      if (inh_q != '0) inh_q <= inh_q - 1'b1;
      if (inc_i) begin
        if (narrow_i) cnt_q[BYTE_W-1:0] <= cnt_q[BYTE_W-1:0] + 1'b1;
        else          cnt_q <= cnt_q + 1'b1;
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  p_load_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q[BYTE_W-1:0] == $past(load_lo_i));
  p_hold_after_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_q != '0 && !load_i) |=> $stable(cnt_q));
  p_off_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  p_hi_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_i |=> $stable(cnt_q[CNT_W-1:BYTE_W]));
  p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t              ctrl_q;
  logic [BYTE_W-1:0]  hbuf_q;
  logic [2*BYTE_W-1:0] cnt;
  logic               flag, run, pin_edge, src, tick;
  logic               load, flag_clr, latch;
  reg_sel_e           sel;

  assign sel      = reg_sel_e'(addr_i);
  assign load     = wr_i & (sel == REG_LOW);
  assign flag_clr = wr_i & (sel == REG_FLAG);
  assign latch    = rd_i & ~wr_i & (sel == REG_LOW);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      ctrl_q <= '1;
    else if (wr_i && sel == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                      hbuf_q <= '0;
    else if (wr_i && sel == REG_HBUF) hbuf_q <= wdata_i;
    else if (latch)                   hbuf_q <= cnt[2*BYTE_W-1:BYTE_W];

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .fall_i(ctrl_q.fall_edge), .edge_o(pin_edge)
  );

  assign src = ctrl_q.ext_src ? pin_edge : 1'b1;

  tmr_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk_i   (clk_i), .rst_ni(rst_ni), .adv_i(run & src), .clr_i(load),
    .bypass_i(ctrl_q.no_div), .code_i(ctrl_q.div_code), .tick_o(tick)
  );

  tmr_core #(.BYTE_W(BYTE_W), .INH_CYC(INH_CYC)) u_core (
    .clk_i     (clk_i), .rst_ni(rst_ni), .en_i(ctrl_q.run),
    .narrow_i  (ctrl_q.narrow), .load_i(load), .load_lo_i(wdata_i),
    .load_hi_i (hbuf_q), .inc_i(tick), .flag_clr_i(flag_clr),
    .cnt_o     (cnt), .flag_o(flag), .run_o(run)
  );

  always_comb
    case (sel)
      REG_CTRL: rdata_o = ctrl_q;
      REG_LOW:  rdata_o = cnt[BYTE_W-1:0];
      REG_HBUF: rdata_o = hbuf_q;
      default:  rdata_o = {{(BYTE_W-1){1'b0}}, flag};
    endcase

  assign irq_o = flag;

  p_buf_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> hbuf_q == $past(cnt[2*BYTE_W-1:BYTE_W]));
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tmr_unit u_tmr_unit (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i) wr_i = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] v);
    addr_i = a; #1 v = rdata_o;
  endtask

  task automatic rd_latch(output logic [7:0] v);
    addr_i = 2'd1; rd_i = 1'b1; #1 v = rdata_o;
    @(negedge clk_i) rd_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    repeat (5) @(negedge clk_i);
    peek(0, v); chk("R1 ctrl", v, 8'hFF);
    peek(1, v); chk("R1 low", v, 8'h00);
    peek(2, v); chk("R1 buf", v, 8'h00);
    peek(3, v); chk("R1 flag", v, 8'h00);
  endtask

  task automatic t_internal;
    logic [7:0] v;
    wr(0, 8'h88);
    wr(1, 8'h10);
    peek(1, v); chk("R7 hold0", v, 8'h10);
    @(negedge clk_i); peek(1, v); chk("R7 hold1", v, 8'h10);
    @(negedge clk_i); peek(1, v); chk("R7 hold2", v, 8'h10);
    @(negedge clk_i); peek(1, v); chk("R2 first", v, 8'h11);
    repeat (7) @(negedge clk_i); peek(1, v); chk("R2 run", v, 8'h18);
  endtask

  task automatic t_prescale(logic [2:0] code);
    logic [7:0] v;
    int n = 2 << code;
    wr(0, {5'b10000, code});
    wr(1, 8'h00);
    repeat (n + 1) @(negedge clk_i); peek(1, v); chk("R3 before", v, 8'h00);
    @(negedge clk_i); peek(1, v); chk("R3 first", v, 8'h01);
    repeat (n) @(negedge clk_i); peek(1, v); chk("R3 second", v, 8'h02);
  endtask

  task automatic t_pre_clear;
    logic [7:0] v;
    wr(0, 8'h82);
    repeat (5) @(negedge clk_i);
    wr(1, 8'h00);
    repeat (9) @(negedge clk_i); peek(1, v); chk("R8 restart wait", v, 8'h00);
    @(negedge clk_i); peek(1, v); chk("R8 restart tick", v, 8'h01);
  endtask

  task automatic pulse_pin(int k);
    for (int i = 0; i < k; i++) begin
      pin_i = 1'b1; repeat (3) @(negedge clk_i);
      pin_i = 1'b0; repeat (3) @(negedge clk_i);
    end
  endtask

  task automatic t_pin;
    logic [7:0] v;
    wr(0, 8'hA8);
    wr(1, 8'h00);
    repeat (4) @(negedge clk_i);
    pulse_pin(5);
    repeat (4) @(negedge clk_i); peek(1, v); chk("R4 rising", v, 8'h05);
    wr(0, 8'hB8);
    wr(1, 8'h00);
    repeat (4) @(negedge clk_i);
    pulse_pin(2);
    pin_i = 1'b1; repeat (5) @(negedge clk_i);
    peek(1, v); chk("R4 falling mid", v, 8'h02);
    pin_i = 1'b0; repeat (5) @(negedge clk_i);
    peek(1, v); chk("R4 falling", v, 8'h03);
  endtask

  task automatic t_buffer;
    logic [7:0] v;
    wr(0, 8'h88);
    wr(2, 8'h12);
    wr(1, 8'hF0);
    repeat (4) @(negedge clk_i);
    rd_latch(v); chk("R5 low", v, 8'hF2);
    peek(2, v); chk("R6 commit hi", v, 8'h12);
    repeat (20) @(negedge clk_i);
    peek(2, v); chk("R5 buf stable", v, 8'h12);
    rd_latch(v); chk("R5 low2", v, 8'h07);
    peek(2, v); chk("R5 buf new", v, 8'h13);
    wr(2, 8'hAB);
    wr(1, 8'hCD);
    peek(1, v); chk("R6 low", v, 8'hCD);
    rd_latch(v);
    peek(2, v); chk("R6 high", v, 8'hAB);
  endtask

  task automatic t_wrap8;
    logic [7:0] v;
    wr(0, 8'h88);
    wr(2, 8'h55);
    wr(1, 8'h00);
    wr(0, 8'hC8);
    wr(3, 8'h00);
    wr(1, 8'hFD);
    repeat (4) @(negedge clk_i);
    peek(1, v); chk("R9 at FF", v, 8'hFF);
    peek(3, v); chk("R9 no flag", v, 8'h00);
    @(negedge clk_i);
    peek(1, v); chk("R9 wrap", v, 8'h00);
    peek(3, v); chk("R9 flag", v, 8'h01);
    wr(0, 8'h48);
    rd_latch(v);
    peek(2, v); chk("R9 hi kept", v, 8'h55);
  endtask

  task automatic t_wrap16;
    logic [7:0] v;
    wr(0, 8'h88);
    wr(3, 8'h00);
    wr(2, 8'hFF);
    wr(1, 8'hFE);
    repeat (3) @(negedge clk_i);
    peek(3, v); chk("R10 no flag", v, 8'h00);
    @(negedge clk_i);
    chk("R10 irq", {7'd0, irq_o}, 8'h01);
    rd_latch(v); chk("R10 low", v, 8'h00);
    peek(2, v); chk("R10 high", v, 8'h00);
    repeat (10) @(negedge clk_i);
    peek(3, v); chk("R11 sticky", v, 8'h01);
    wr(3, 8'h00);
    peek(3, v); chk("R11 cleared", v, 8'h00);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    wr(0, 8'h08);
    wr(1, 8'h40);
    repeat (10) @(negedge clk_i);
    peek(1, v); chk("R12 frozen", v, 8'h40);
    wr(0, 8'h02);
    wr(1, 8'h00);
    repeat (10) @(negedge clk_i);
    wr(0, 8'h82);
    repeat (7) @(negedge clk_i); peek(1, v); chk("R12 pre held", v, 8'h00);
    @(negedge clk_i); peek(1, v); chk("R12 pre tick", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_internal();
    t_prescale(3'd0);
    t_prescale(3'd3);
    t_prescale(3'd7);
    t_pre_clear();
    t_pin();
    t_buffer();
    t_wrap8();
    t_wrap16();
    t_disable();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule